// File: doc/BRIEF.md
# Slave Frame-Sync Timing Checker

This block watches the frame-sync line of an audio serial port that runs as a slave, where an external master drives the bit clock and the frame sync. It counts bit-clock periods from each accepted frame-sync edge. It then checks every new edge against the programmed frame length. A sync edge that comes too soon raises an early error. A sync that is missing when the frame length runs out raises a late error.

Both errors are held in sticky flags. Each flag has its own clear strobe and its own interrupt enable. The checker only runs when the port is a slave and the selected protocol is the free-format one. In master mode, and in the S/PDIF and AC'97 protocol modes, it stays parked and sets no flag.

The programmed field `frame_len_i` holds the frame length minus one. A frame is therefore `frame_len_i + 1` bit clocks long. The block runs on the system clock, and `bclk_en_i` marks the cycles that carry one bit-clock sample.

Top module: `fs_sync_checker`

## Requirements
- R1: When a frame-sync edge arrives exactly `frame_len_i + 1` enabled bit clocks after the previous accepted edge, neither flag is set. Only cycles with `bclk_en_i` high are counted.
- R2: When a sync edge arrives before `frame_len_i + 1` bit clocks have elapsed, `early_flag_o` is set from the next clock on. The count then realigns to that edge, so later frames of nominal length raise no error.
- R3: When the bit clock at position `frame_len_i + 1` carries no sync edge, `late_flag_o` is set from the next clock on. The checker then waits for the next sync edge, which realigns the count and raises no early error.
- R4: The first sync edge after the checker becomes active only aligns the count and never sets a flag, whatever came before it.
- R5: While `master_i` is 1, neither flag is set and the count stays unaligned.
- R6: `proto_i` selects the protocol: 2'b00 free format, 2'b01 S/PDIF, 2'b10 AC'97, 2'b11 free format. Under 2'b01 and 2'b10 neither flag is set. Under 2'b00 and 2'b11 the checker runs.
- R7: Each flag resets to 0 and stays at 1 until its own clear strobe is high on a clock edge. If a new error and a clear fall on the same edge, the flag stays set.
- R8: `early_irq_o` equals `early_flag_o AND ie_early_i`, and `late_irq_o` equals `late_flag_o AND ie_late_i`, with no added delay.
- R9: The active sync edge is a 0-to-1 change of `fs_i` between two successive enabled bit-clock samples. A pulse on `fs_i` in cycles where `bclk_en_i` is low is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_en_i | input | 1 | One-cycle strobe per bit-clock sample |
| fs_i | input | 1 | Frame-sync line, active high |
| frame_len_i | input | FRL_W | Frame length minus one, in bit clocks |
| master_i | input | 1 | 1 = port is master, so the checker is off |
| proto_i | input | 2 | Protocol select, encoded as in R6 |
| clr_early_i | input | 1 | Clear strobe for the early flag |
| clr_late_i | input | 1 | Clear strobe for the late flag |
| ie_early_i | input | 1 | Interrupt enable for the early flag |
| ie_late_i | input | 1 | Interrupt enable for the late flag |
| early_flag_o | output | 1 | Sticky early-sync error |
| late_flag_o | output | 1 | Sticky late-sync error |
| early_irq_o | output | 1 | Masked early interrupt request |
| late_irq_o | output | 1 | Masked late interrupt request |

## Verification
The hardest case to reach from the ports is a new early error and a clear strobe landing on the same clock edge. The bench reaches it by locking onto nominal frames, shortening one frame, and raising `clr_early_i` inside the very bit-clock cycle that carries the premature edge.

A second subtle case is recovery after a late error. Here the bench sends several nominal frames and checks that they raise no early error, which shows that the count realigned on the next edge. It also pulses `fs_i` between bit-clock strobes to show that such a pulse is never taken as an edge.

// File: rtl/fs_chk_pkg.sv
package fs_chk_pkg;
  typedef enum logic [1:0] {
    PROTO_FREE  = 2'b00,
    PROTO_SPDIF = 2'b01,
    PROTO_AC97  = 2'b10,
    PROTO_FREE2 = 2'b11
  } proto_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_e;
endpackage

// File: rtl/fs_edge_det.sv
module fs_edge_det #(
  parameter bit FS_ACT_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic fs_i,
  output logic edge_o
);
  logic lvl, lvl_q;

  generate
    if (FS_ACT_HIGH) begin : g_pos
      assign lvl = fs_i;
    end else begin : g_neg
      assign lvl = ~fs_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= 1'b0;
    else if (smp_i) lvl_q <= lvl;
  end

  assign edge_o = smp_i & lvl & ~lvl_q;
endmodule

// File: rtl/fs_frame_cnt.sv
module fs_frame_cnt
  import fs_chk_pkg::*;
#(
  parameter int FRL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic [FRL_W-1:0] frl_i,
  output logic             early_o,
  output logic             late_o,
  output logic             locked_o
);
  localparam int CNT_W = FRL_W + 1;

  lock_e            st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, exp_len;

  assign exp_len = CNT_W'(frl_i) + CNT_W'(1);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    early_o = 1'b0;
    late_o  = 1'b0;
    if (!active_i) begin
      st_d  = ST_HUNT;
      cnt_d = '0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_HUNT: begin
          if (edge_i) begin
            st_d  = ST_LOCK;
            cnt_d = CNT_W'(1);
          end
        end
        ST_LOCK: begin
          if (edge_i) begin
            early_o = (cnt_q < exp_len);
            cnt_d   = CNT_W'(1);
          end else if (cnt_q >= exp_len) begin
            // missing sync: drop lock, wait for next edge
            late_o = 1'b1;
            st_d   = ST_HUNT;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign locked_o = (st_q == ST_LOCK);
endmodule

// File: rtl/fs_sticky_flag.sv
module fs_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/fs_sync_checker.sv
module fs_sync_checker
  import fs_chk_pkg::*;
#(
  parameter int FRL_W       = 8,
  parameter bit FS_ACT_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_en_i,
  input  logic             fs_i,
  input  logic [FRL_W-1:0] frame_len_i,
  input  logic             master_i,
  input  logic [1:0]       proto_i,
  input  logic             clr_early_i,
  input  logic             clr_late_i,
  input  logic             ie_early_i,
  input  logic             ie_late_i,
  output logic             early_flag_o,
  output logic             late_flag_o,
  output logic             early_irq_o,
  output logic             late_irq_o
);
  localparam int NFLAG = 2;

  logic             active, fs_edge, early_evt, late_evt, locked;
  logic [NFLAG-1:0] set_v, clr_v, ie_v, flg_v, irq_v;

  assign active = ~master_i &
                  ((proto_i == PROTO_FREE) | (proto_i == PROTO_FREE2));

  fs_edge_det #(.FS_ACT_HIGH(FS_ACT_HIGH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (bclk_en_i),
    .fs_i   (fs_i),
    .edge_o (fs_edge)
  );

  fs_frame_cnt #(.FRL_W(FRL_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (bclk_en_i),
    .edge_i   (fs_edge),
    .frl_i    (frame_len_i),
    .early_o  (early_evt),
    .late_o   (late_evt),
    .locked_o (locked)
  );

  assign set_v = {late_evt, early_evt};
  assign clr_v = {clr_late_i, clr_early_i};
  assign ie_v  = {ie_late_i, ie_early_i};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    fs_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[gi]),
      .clr_i  (clr_v[gi]),
      .ie_i   (ie_v[gi]),
      .flag_o (flg_v[gi]),
      .irq_o  (irq_v[gi])
    );
  end

  assign early_flag_o = flg_v[0];
  assign late_flag_o  = flg_v[1];
  assign early_irq_o  = irq_v[0];
  assign late_irq_o   = irq_v[1];
endmodule

// File: rtl/fs_sync_checker_chk.sv
module fs_sync_checker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bclk_en_i,
  input logic       master_i,
  input logic [1:0] proto_i,
  input logic       clr_early_i,
  input logic       ie_late_i,
  input logic       early_flag_o,
  input logic       late_flag_o,
  input logic       late_irq_o,
  input logic       locked
);
  AST_NO_TICK_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bclk_en_i && !early_flag_o) |=> !early_flag_o); // R1
  AST_MASTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !early_flag_o) |=> !early_flag_o); // R5
  AST_MASTER_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> !locked); // R5
  AST_PROTO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((proto_i == 2'b01 || proto_i == 2'b10) && !late_flag_o) |=> !late_flag_o); // R6
  AST_EARLY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_flag_o && !clr_early_i) |=> early_flag_o); // R7
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_early_i && !bclk_en_i) |=> !early_flag_o); // R7
  AST_LATE_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_irq_o |-> ie_late_i); // R8
endmodule

bind fs_sync_checker fs_sync_checker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bclk_en_i    (bclk_en_i),
  .master_i     (master_i),
  .proto_i      (proto_i),
  .clr_early_i  (clr_early_i),
  .ie_late_i    (ie_late_i),
  .early_flag_o (early_flag_o),
  .late_flag_o  (late_flag_o),
  .late_irq_o   (late_irq_o),
  .locked       (locked)
);

// File: tb/sim_fs_sync_checker.sv
`timescale 1ns/1ps
module sim_fs_sync_checker;
  localparam int FRL_W = 8;
  localparam int FLEN  = 8; // frame_len_i = 7

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             bclk_en_i, fs_i, master_i;
  logic [FRL_W-1:0] frame_len_i;
  logic [1:0]       proto_i;
  logic             clr_early_i, clr_late_i, ie_early_i, ie_late_i;
  logic             early_flag_o, late_flag_o, early_irq_o, late_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  fs_sync_checker #(.FRL_W(FRL_W)) u0 (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bit_(input logic fs, input logic ce = 1'b0);
    @(negedge clk_i);
    fs_i = fs; bclk_en_i = 1'b1; clr_early_i = ce;
    @(negedge clk_i);
    bclk_en_i = 1'b0; clr_early_i = 1'b0;
  endtask

  task automatic frame(input int n, input logic sync);
    for (int i = 0; i < n; i++) bit_((i == 0) ? sync : 1'b0);
  endtask

  task automatic clr_both();
    @(negedge clk_i);
    clr_early_i = 1'b1; clr_late_i = 1'b1;
    @(negedge clk_i);
    clr_early_i = 1'b0; clr_late_i = 1'b0;
  endtask

  task automatic prep();
    master_i = 1'b1; proto_i = 2'b00; ie_early_i = 1'b0; ie_late_i = 1'b0;
    bit_(1'b0);
    clr_both();
    master_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 reset early", early_flag_o, 1'b0);
    check("R7 reset late", late_flag_o, 1'b0);
    check("R8 reset irq", early_irq_o | late_irq_o, 1'b0);
  endtask

  task automatic t_nominal();
    prep();
    for (int k = 0; k < 4; k++) frame(FLEN, 1'b1);
    bit_(1'b1);
    check("R1 nominal early", early_flag_o, 1'b0);
    check("R1 nominal late", late_flag_o, 1'b0);
  endtask

  task automatic t_early();
    prep();
    frame(FLEN, 1'b1);
    frame(5, 1'b1);
    frame(FLEN, 1'b1);
    check("R2 early set", early_flag_o, 1'b1);
    check("R2 no late", late_flag_o, 1'b0);
    clr_both();
    frame(FLEN, 1'b1);
    frame(FLEN, 1'b1);
    check("R2 realigned", early_flag_o, 1'b0);
  endtask

  task automatic t_late();
    prep();
    frame(FLEN, 1'b1);
    frame(4, 1'b0);
    check("R3 late set", late_flag_o, 1'b1);
    check("R3 no early", early_flag_o, 1'b0);
    for (int k = 0; k < 3; k++) frame(FLEN, 1'b1);
    check("R3 resync no early", early_flag_o, 1'b0);
    clr_both();
    frame(FLEN, 1'b1);
    check("R3 resync no late", late_flag_o, 1'b0);
  endtask

  task automatic t_first();
    prep();
    frame(3, 1'b0);
    bit_(1'b1);
    check("R4 first edge early", early_flag_o, 1'b0);
    for (int i = 1; i < FLEN; i++) bit_(1'b0);
    frame(FLEN, 1'b1);
    check("R4 first edge late", late_flag_o, 1'b0);
  endtask

  task automatic t_master();
    prep();
    master_i = 1'b1;
    for (int k = 0; k < 3; k++) frame(5, 1'b1);
    frame(20, 1'b0);
    check("R5 master early", early_flag_o, 1'b0);
    check("R5 master late", late_flag_o, 1'b0);
  endtask

  task automatic t_proto();
    for (int p = 1; p < 3; p++) begin
      prep();
      proto_i = 2'(p);
      frame(FLEN, 1'b1);
      frame(3, 1'b1);
      frame(3, 1'b1);
      frame(20, 1'b0);
      check("R6 proto early", early_flag_o, 1'b0);
      check("R6 proto late", late_flag_o, 1'b0);
    end
    prep();
    proto_i = 2'b11;
    frame(FLEN, 1'b1);
    frame(3, 1'b1);
    bit_(1'b1);
    check("R6 proto 11 runs", early_flag_o, 1'b1);
    proto_i = 2'b00;
  endtask

  task automatic t_sticky();
    prep();
    frame(FLEN, 1'b1);
    frame(3, 1'b1);
    bit_(1'b1, 1'b1);
    check("R7 set wins over clear", early_flag_o, 1'b1);
    repeat (10) @(negedge clk_i);
    check("R7 sticky hold", early_flag_o, 1'b1);
    @(negedge clk_i); clr_early_i = 1'b1;
    @(negedge clk_i); clr_early_i = 1'b0;
    check("R7 cleared", early_flag_o, 1'b0);
  endtask

  task automatic t_irq();
    prep();
    frame(FLEN, 1'b1);
    frame(2, 1'b1);
    bit_(1'b1);
    ie_early_i = 1'b0;
    #1 check("R8 early masked", early_irq_o, 1'b0);
    ie_early_i = 1'b1;
    #1 check("R8 early irq", early_irq_o, 1'b1);
    ie_late_i = 1'b1;
    #1 check("R8 late idle", late_irq_o, 1'b0);
    frame(FLEN, 1'b0);
    check("R8 late irq", late_irq_o, 1'b1);
    ie_late_i = 1'b0;
    #1 check("R8 late masked", late_irq_o, 1'b0);
    ie_early_i = 1'b0;
  endtask

  task automatic t_edge();
    prep();
    frame(FLEN, 1'b1);
    bit_(1'b1); bit_(1'b1); bit_(1'b1);
    bit_(1'b0);
    @(negedge clk_i); fs_i = 1'b1;
    @(negedge clk_i); fs_i = 1'b0;
    bit_(1'b0); bit_(1'b0); bit_(1'b0); bit_(1'b0);
    frame(FLEN, 1'b1);
    check("R9 level and gap pulse", early_flag_o, 1'b0);
    check("R9 no late", late_flag_o, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0; bclk_en_i = 1'b0; fs_i = 1'b0; master_i = 1'b0;
    proto_i = 2'b00; frame_len_i = FRL_W'(FLEN - 1);
    clr_early_i = 1'b0; clr_late_i = 1'b0; ie_early_i = 1'b0; ie_late_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_nominal();
    t_early();
    t_late();
    t_first();
    t_master();
    t_proto();
    t_sticky();
    t_irq();
    t_edge();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule